// File: doc/BRIEF.md
# Counted Streaming Read Ports

This block gives a processor two auto-advancing read windows. One walks a byte-addressed memory space one 32-bit word at a time. The other walks a space of external word registers one index at a time. Each window has a cursor address and a remaining-word count, and both can be programmed and read back through a small control port. Each strobe on a window reads the word under its cursor. If that window's count is not zero, the same strobe moves the cursor to the next word and lowers the count by one. If the count is zero, the cursor stays where it is, so repeated strobes keep returning the same location.

The block drives the current cursors straight onto an external memory read port and an external register read port, and both ports answer combinationally. Register indices at or above the size of the register space read as zero, whatever the register port returns. The two windows are independent, so both can be strobed in the same cycle. A parameter selects whether the read data leaves the block in the strobe cycle (latency 0) or one cycle later (latency 1, the default). Each window has its own valid output.

Top module: `stream_read_ports`

## Requirements
- R1: A strobe on `mem_rd` returns the 32-bit word that the memory port gives for the current memory cursor, which is shown on `mem_bus_addr`. The word appears on `mem_data` with `mem_data_valid` high, LATENCY cycles after the strobe (default 1). `mem_data_valid` is low in every other cycle.
- R2: When the memory count is not zero, each memory strobe lowers the count by 1 and raises the 64-bit memory cursor by 4. The carry runs from the low 32 bits into the high bits.
- R3: A strobe on `reg_rd` returns the word that the register port gives for the current register cursor, which is shown on `reg_bus_idx`. The word appears on `reg_data` with `reg_data_valid` high after the same latency.
- R4: When the register count is not zero, each register strobe lowers the count by 1 and raises the register cursor by 1.
- R5: When a window's count is zero, a strobe still returns data, and that window's cursor and count do not change.
- R6: A register strobe whose cursor is at or above REG_DEPTH (default 4096) returns 0, whatever `reg_bus_rdata` carries.
- R7: Control register codes on `cfg_sel` are: 0 for memory cursor bits 31:0, 1 for memory cursor bits 63:32, 2 for memory count, 3 for register cursor (zero-extended on read, low REG_ADDR_W bits kept on write), and 4 for register count. A write with `cfg_we` takes effect at the next clock edge. `cfg_rdata` shows the selected value combinationally. Codes 5 to 7 read 0, and writes to them change nothing.
- R8: When a control write hits one of a window's registers in the same cycle as that window's strobe, the read returns data from the cursor as it was before the write. The written value is stored, and that window does not advance in that cycle.
- R9: Strobes on both windows in the same cycle are each serviced and advanced as if they were alone.
- R10: After reset, both cursors and both counts are 0, and both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write enable |
| cfg_sel | input | 3 | Control register code |
| cfg_wdata | input | 32 | Control write data |
| cfg_rdata | output | 32 | Control read-back data |
| mem_rd | input | 1 | Memory window read strobe |
| mem_bus_addr | output | MEM_ADDR_W | Memory cursor sent to the memory read port |
| mem_bus_rdata | input | 32 | Word returned by the memory read port |
| mem_data_valid | output | 1 | Memory window data valid |
| mem_data | output | 32 | Memory window read data |
| reg_rd | input | 1 | Register window read strobe |
| reg_bus_idx | output | REG_ADDR_W | Register cursor sent to the register read port |
| reg_bus_rdata | input | 32 | Word returned by the register read port |
| reg_data_valid | output | 1 | Register window data valid |
| reg_data | output | 32 | Register window read data |

## Verification
The bench starts the memory cursor 8 bytes below a 4 GiB boundary, so a design that drops the carry into the high word reads the wrong location after the third strobe. It strobes past the end of each count. A design that keeps stepping at count zero, or that stops returning data there, produces results that no longer match the bench's expected queue. The register window is walked across the REG_DEPTH limit while the register port returns nonzero values, which exposes any failure to force out-of-range reads to zero. The bench also writes a count in the same cycle as a strobe and strobes both windows together, which catches a design that lets the write and the advance fight, or that couples the two windows.

// File: rtl/srp_pkg.sv
package srp_pkg;
   localparam int WORD_W   = 32;
   localparam int MEM_STEP = 4;
   localparam int REG_STEP = 1;

   typedef enum logic [2:0] {
      SEL_MEM_ADDR_LO = 3'd0,
      SEL_MEM_ADDR_HI = 3'd1,
      SEL_MEM_CNT     = 3'd2,
      SEL_REG_ADDR    = 3'd3,
      SEL_REG_CNT     = 3'd4
   } cfg_sel_e;
endpackage

// File: rtl/srp_cursor.sv
// Address/count pair that steps by STEP while the count is nonzero.
module srp_cursor #(
   parameter int ADDR_W = 64,
   parameter int CNT_W  = 32,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              wr_cnt,
   input  logic [31:0]       wdata,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  cnt
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr_w
      $error("srp_cursor: ADDR_W must be 1..64");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("srp_cursor: CNT_W must be 1..32");
   end

   logic              any_wr;
   logic              fire;
   logic [ADDR_W-1:0] addr_wval;

   assign any_wr = wr_lo | wr_hi | wr_cnt;
   assign fire   = adv && (cnt != '0) && !any_wr;

   if (ADDR_W > 32) begin : g_split
      assign addr_wval = {wr_hi ? wdata[ADDR_W-33:0] : addr[ADDR_W-1:32],
                          wr_lo ? wdata              : addr[31:0]};
   end else begin : g_flat
      assign addr_wval = wr_lo ? wdata[ADDR_W-1:0] : addr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
         cnt  <= '0;
      end else begin
         if (wr_cnt)
            cnt <= wdata[CNT_W-1:0];
         else if (fire)
            cnt <= cnt - 1'b1;

         if (wr_lo || wr_hi)
            addr <= addr_wval;
         else if (fire)
            addr <= addr + STEP_V;
      end
   end
endmodule

// File: rtl/srp_out_stage.sv
// Output timing variant: pass-through or one register stage.
module srp_out_stage #(
   parameter int LATENCY = 1,
   parameter int W       = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd,
   input  logic [W-1:0] din,
   output logic         valid,
   output logic [W-1:0] dout
);
   if (LATENCY != 0 && LATENCY != 1) begin : g_bad_lat
      $error("srp_out_stage: LATENCY must be 0 or 1");
   end

   if (LATENCY == 0) begin : g_comb
      assign valid = rd;
      assign dout  = din;
   end else begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
         end else begin
            valid <= rd;
            if (rd)
               dout <= din;
         end
      end
   end
endmodule

// File: rtl/stream_read_ports.sv
module stream_read_ports
   import srp_pkg::*;
#(
   parameter int MEM_ADDR_W = 64,
   parameter int REG_ADDR_W = 16,
   parameter int CNT_W      = 32,
   parameter int REG_DEPTH  = 4096,
   parameter int LATENCY    = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [2:0]            cfg_sel,
   input  logic [31:0]           cfg_wdata,
   output logic [31:0]           cfg_rdata,
   input  logic                  mem_rd,
   output logic [MEM_ADDR_W-1:0] mem_bus_addr,
   input  logic [31:0]           mem_bus_rdata,
   output logic                  mem_data_valid,
   output logic [31:0]           mem_data,
   input  logic                  reg_rd,
   output logic [REG_ADDR_W-1:0] reg_bus_idx,
   input  logic [31:0]           reg_bus_rdata,
   output logic                  reg_data_valid,
   output logic [31:0]           reg_data
);
   localparam int REG_SPACE = 1 << REG_ADDR_W;

   if (MEM_ADDR_W <= 32 || MEM_ADDR_W > 64) begin : g_bad_mem_w
      $error("stream_read_ports: MEM_ADDR_W must be 33..64");
   end
   if (REG_ADDR_W < 1 || REG_ADDR_W > 30) begin : g_bad_reg_w
      $error("stream_read_ports: REG_ADDR_W must be 1..30");
   end
   if (REG_DEPTH < 1 || REG_DEPTH > REG_SPACE) begin : g_bad_depth
      $error("stream_read_ports: REG_DEPTH out of range");
   end

   logic [MEM_ADDR_W-1:0] mem_addr;
   logic [CNT_W-1:0]      mem_cnt;
   logic [REG_ADDR_W-1:0] reg_addr;
   logic [CNT_W-1:0]      reg_cnt;
   logic                  reg_in_range;
   logic [31:0]           reg_src;

   // control write decode
   logic wr_mlo, wr_mhi, wr_mcnt, wr_radr, wr_rcnt;
   assign wr_mlo  = cfg_we && (cfg_sel == SEL_MEM_ADDR_LO);
   assign wr_mhi  = cfg_we && (cfg_sel == SEL_MEM_ADDR_HI);
   assign wr_mcnt = cfg_we && (cfg_sel == SEL_MEM_CNT);
   assign wr_radr = cfg_we && (cfg_sel == SEL_REG_ADDR);
   assign wr_rcnt = cfg_we && (cfg_sel == SEL_REG_CNT);

   srp_cursor #(.ADDR_W(MEM_ADDR_W), .CNT_W(CNT_W), .STEP(MEM_STEP)) u_mem_cur (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (mem_rd),
      .wr_lo  (wr_mlo),
      .wr_hi  (wr_mhi),
      .wr_cnt (wr_mcnt),
      .wdata  (cfg_wdata),
      .addr   (mem_addr),
      .cnt    (mem_cnt)
   );

   srp_cursor #(.ADDR_W(REG_ADDR_W), .CNT_W(CNT_W), .STEP(REG_STEP)) u_reg_cur (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (reg_rd),
      .wr_lo  (wr_radr),
      .wr_hi  (1'b0),
      .wr_cnt (wr_rcnt),
      .wdata  (cfg_wdata),
      .addr   (reg_addr),
      .cnt    (reg_cnt)
   );

   assign mem_bus_addr = mem_addr;
   assign reg_bus_idx  = reg_addr;

   // register-space range limit
   if (REG_DEPTH >= REG_SPACE) begin : g_full_space
      assign reg_in_range = 1'b1;
   end else begin : g_part_space
      assign reg_in_range = reg_addr < REG_ADDR_W'(REG_DEPTH);
   end
   assign reg_src = reg_in_range ? reg_bus_rdata : '0;

   srp_out_stage #(.LATENCY(LATENCY), .W(WORD_W)) u_mem_out (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (mem_rd),
      .din   (mem_bus_rdata),
      .valid (mem_data_valid),
      .dout  (mem_data)
   );

   srp_out_stage #(.LATENCY(LATENCY), .W(WORD_W)) u_reg_out (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (reg_rd),
      .din   (reg_src),
      .valid (reg_data_valid),
      .dout  (reg_data)
   );

   // control read-back
   always_comb begin
      cfg_rdata = '0;
      case (cfg_sel)
         SEL_MEM_ADDR_LO: cfg_rdata = mem_addr[31:0];
         SEL_MEM_ADDR_HI: cfg_rdata = 32'(mem_addr[MEM_ADDR_W-1:32]);
         SEL_MEM_CNT:     cfg_rdata = 32'(mem_cnt);
         SEL_REG_ADDR:    cfg_rdata = 32'(reg_addr);
         SEL_REG_CNT:     cfg_rdata = 32'(reg_cnt);
         default:         cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
   parameter int MEM_ADDR_W = 64,
   parameter int REG_ADDR_W = 16,
   parameter int CNT_W      = 32,
   parameter int REG_DEPTH  = 4096,
   parameter int LATENCY    = 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_we,
   input logic [2:0]            cfg_sel,
   input logic [31:0]           cfg_wdata,
   input logic                  mem_rd,
   input logic                  reg_rd,
   input logic [MEM_ADDR_W-1:0] mem_addr,
   input logic [CNT_W-1:0]      mem_cnt,
   input logic [REG_ADDR_W-1:0] reg_addr,
   input logic [CNT_W-1:0]      reg_cnt,
   input logic                  mem_data_valid,
   input logic                  reg_data_valid,
   input logic [31:0]           reg_data
);
   logic mem_touch, reg_touch;
   assign mem_touch = cfg_we && (cfg_sel <= 3'd2);
   assign reg_touch = cfg_we && (cfg_sel == 3'd3 || cfg_sel == 3'd4);

   // R2
   a_r2_mem_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mem_cnt != '0 && !mem_touch) |=>
         (mem_addr == $past(mem_addr) + MEM_ADDR_W'(4)) && (mem_cnt == $past(mem_cnt) - 1'b1));

   // R4
   a_r4_reg_step: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_cnt != '0 && !reg_touch) |=>
         (reg_addr == $past(reg_addr) + 1'b1) && (reg_cnt == $past(reg_cnt) - 1'b1));

   // R5
   a_r5_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cnt == '0 && !mem_touch) |=> $stable(mem_addr) && $stable(mem_cnt));

   a_r5_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_cnt == '0 && !reg_touch) |=> $stable(reg_addr) && $stable(reg_cnt));

   // R8
   a_r8_cnt_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 3'd2) |=> mem_cnt == $past(cfg_wdata[CNT_W-1:0]));

   // R7
   a_r7_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel > 3'd4 && !mem_rd && !reg_rd) |=>
         $stable(mem_addr) && $stable(mem_cnt) && $stable(reg_addr) && $stable(reg_cnt));

   if (LATENCY == 1) begin : g_lat1
      // R1
      a_r1_mem_valid: assert property (@(posedge clk) disable iff (!rst_n)
         mem_rd |=> mem_data_valid);
      // R9
      a_r9_both_valid: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_rd && reg_rd) |=> (mem_data_valid && reg_data_valid));
      // R6
      a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_rd && {1'b0, reg_addr} >= (REG_ADDR_W+1)'(REG_DEPTH)) |=> reg_data == 32'd0);
   end
endmodule

bind stream_read_ports srp_checker #(
   .MEM_ADDR_W (MEM_ADDR_W),
   .REG_ADDR_W (REG_ADDR_W),
   .CNT_W      (CNT_W),
   .REG_DEPTH  (REG_DEPTH),
   .LATENCY    (LATENCY)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_we         (cfg_we),
   .cfg_sel        (cfg_sel),
   .cfg_wdata      (cfg_wdata),
   .mem_rd         (mem_rd),
   .reg_rd         (reg_rd),
   .mem_addr       (mem_addr),
   .mem_cnt        (mem_cnt),
   .reg_addr       (reg_addr),
   .reg_cnt        (reg_cnt),
   .mem_data_valid (mem_data_valid),
   .reg_data_valid (reg_data_valid),
   .reg_data       (reg_data)
);

// File: tb/stream_read_ports_tb.sv
module stream_read_ports_tb;
   localparam int DEPTH = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic [31:0] cfg_rdata;
   logic        mem_rd = 1'b0;
   logic [63:0] mem_bus_addr;
   logic [31:0] mem_bus_rdata;
   logic        mem_data_valid;
   logic [31:0] mem_data;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_bus_idx;
   logic [31:0] reg_bus_rdata;
   logic        reg_data_valid;
   logic [31:0] reg_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit mon_on   = 1'b0;
   bit done     = 1'b0;

   // bench mirror of cursor state, derived from the requirements
   logic [63:0] bm_addr = 64'd0;
   logic [31:0] bm_cnt  = 32'd0;
   logic [15:0] br_addr = 16'd0;
   logic [31:0] br_cnt  = 32'd0;

   logic [31:0] mq[$];
   string       mtag[$];
   logic [31:0] rq[$];
   string       rtag[$];

   always #2 clk = ~clk;

   function automatic logic [31:0] mem_model(input logic [63:0] a);
      return (a[31:0] * 32'h9E37_79B1) ^ a[63:32] ^ 32'h1357_0000;
   endfunction
   function automatic logic [31:0] reg_model(input logic [15:0] i);
      return 32'h5000_0000 | (32'(i) * 32'd3);
   endfunction

   assign mem_bus_rdata = mem_model(mem_bus_addr);
   assign reg_bus_rdata = reg_model(reg_bus_idx);

   stream_read_ports u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .mem_rd(mem_rd), .mem_bus_addr(mem_bus_addr), .mem_bus_rdata(mem_bus_rdata),
      .mem_data_valid(mem_data_valid), .mem_data(mem_data),
      .reg_rd(reg_rd), .reg_bus_idx(reg_bus_idx), .reg_bus_rdata(reg_bus_rdata),
      .reg_data_valid(reg_data_valid), .reg_data(reg_data)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: one cycle of stimulus, pushes expected results
   task automatic step(input bit mrd, input bit rrd, input bit we,
                       input logic [2:0] sel, input logic [31:0] wd, input string tag);
      bit mtouch, rtouch;
      @(negedge clk);
      mem_rd = mrd; reg_rd = rrd; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
      if (mrd) begin
         mq.push_back(mem_model(bm_addr));
         mtag.push_back(tag);
      end
      if (rrd) begin
         rq.push_back((br_addr < 16'(DEPTH)) ? reg_model(br_addr) : 32'd0);
         rtag.push_back(tag);
      end
      mtouch = we && sel <= 3'd2;
      rtouch = we && (sel == 3'd3 || sel == 3'd4);
      if (we) begin
         case (sel)
            3'd0: bm_addr[31:0]  = wd;
            3'd1: bm_addr[63:32] = wd;
            3'd2: bm_cnt         = wd;
            3'd3: br_addr        = wd[15:0];
            3'd4: br_cnt         = wd;
            default: ;
         endcase
      end
      if (mrd && !mtouch && bm_cnt != 0) begin
         bm_cnt--; bm_addr = bm_addr + 64'd4;
      end
      if (rrd && !rtouch && br_cnt != 0) begin
         br_cnt--; br_addr = br_addr + 16'd1;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 3'd0, 32'd0, "idle");
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] wd);
      step(1'b0, 1'b0, 1'b1, sel, wd, "R7");
   endtask

   task automatic readback(input logic [2:0] sel, input logic [31:0] exp, input string tag);
      @(negedge clk);
      mem_rd = 1'b0; reg_rd = 1'b0; cfg_we = 1'b0; cfg_sel = sel;
      #1;
      check(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
   endtask

   // monitor: pops expected items as valid results appear
   always @(negedge clk) begin
      if (mon_on) begin
         if (mem_data_valid) begin
            if (mq.size() == 0)
               check(1'b0, "R1 spurious mem valid", 64'(mem_data), 64'd0);
            else begin
               automatic logic [31:0] e = mq.pop_front();
               automatic string t = mtag.pop_front();
               check(mem_data == e, {t, " mem data"}, 64'(mem_data), 64'(e));
            end
         end
         if (reg_data_valid) begin
            if (rq.size() == 0)
               check(1'b0, "R3 spurious reg valid", 64'(reg_data), 64'd0);
            else begin
               automatic logic [31:0] e = rq.pop_front();
               automatic string t = rtag.pop_front();
               check(reg_data == e, {t, " reg data"}, 64'(reg_data), 64'(e));
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state
      readback(3'd0, 32'd0, "R10 mem addr lo");
      readback(3'd1, 32'd0, "R10 mem addr hi");
      readback(3'd2, 32'd0, "R10 mem cnt");
      readback(3'd3, 32'd0, "R10 reg addr");
      readback(3'd4, 32'd0, "R10 reg cnt");
      check(!mem_data_valid && !reg_data_valid, "R10 valids low",
            64'({mem_data_valid, reg_data_valid}), 64'd0);
      mon_on = 1'b1;

      // R1 R2 R5: memory walk across the 32-bit carry, past count end
      wr(3'd0, 32'hFFFF_FFF8);
      wr(3'd1, 32'h0000_0001);
      wr(3'd2, 32'd3);
      readback(3'd0, 32'hFFFF_FFF8, "R7 mem lo readback");
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 3'd0, 32'd0, "R2");
      for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b0, 3'd0, 32'd0, "R5");
      idle(1);
      readback(3'd0, 32'h0000_0004, "R2 mem lo after carry");
      readback(3'd1, 32'h0000_0002, "R2 mem hi after carry");
      readback(3'd2, 32'd0, "R5 mem cnt stays 0");

      // R3 R4 R6: register walk across REG_DEPTH
      wr(3'd3, 32'd4094);
      wr(3'd4, 32'd4);
      for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 1'b0, 3'd0, 32'd0, "R4");
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 3'd0, 32'd0, "R6");
      idle(1);
      readback(3'd3, 32'd4098, "R4 reg addr");
      readback(3'd4, 32'd0, "R4 reg cnt");

      // R5 in range, unprogrammed count keeps same location
      wr(3'd3, 32'd10);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 3'd0, 32'd0, "R5");
      idle(1);
      readback(3'd3, 32'd10, "R5 reg addr held");

      // R9: both windows together
      wr(3'd0, 32'h0000_0100);
      wr(3'd1, 32'd0);
      wr(3'd2, 32'd2);
      wr(3'd3, 32'd7);
      wr(3'd4, 32'd2);
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 3'd0, 32'd0, "R9");
      idle(1);
      readback(3'd0, 32'h0000_0108, "R9 mem addr");
      readback(3'd3, 32'd9, "R9 reg addr");

      // R8: count write coincides with memory strobe
      step(1'b1, 1'b0, 1'b1, 3'd2, 32'd5, "R8");
      idle(1);
      readback(3'd2, 32'd5, "R8 written count kept");
      readback(3'd0, 32'h0000_0108, "R8 no advance");
      step(1'b1, 1'b0, 1'b0, 3'd0, 32'd0, "R8");
      idle(1);
      readback(3'd0, 32'h0000_010C, "R8 next read advances");
      readback(3'd2, 32'd4, "R8 count after");

      // R7: unused codes and register cursor width
      step(1'b0, 1'b0, 1'b1, 3'd5, 32'hDEAD_BEEF, "R7");
      step(1'b0, 1'b0, 1'b1, 3'd7, 32'hDEAD_BEEF, "R7");
      readback(3'd5, 32'd0, "R7 code 5 reads 0");
      readback(3'd7, 32'd0, "R7 code 7 reads 0");
      readback(3'd0, 32'h0000_010C, "R7 mem lo untouched");
      readback(3'd2, 32'd4, "R7 mem cnt untouched");
      readback(3'd4, 32'd0, "R7 reg cnt untouched");
      wr(3'd3, 32'hABCD_1234);
      readback(3'd3, 32'h0000_1234, "R7 reg addr truncated");

      idle(2);
      check(mq.size() == 0 && rq.size() == 0, "R1 all results delivered",
            64'(mq.size() + rq.size()), 64'd0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R1 watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule